// File: doc/BRIEF.md
# Watchdog Timer with Interval Prescaler

The block guards a CPU against a program that has gone astray. A free-running prescaler divides the system clock by a power of two between 8 and 1024. A binary interval counter counts the divided ticks, and each wrap of that counter emits an interval interrupt pulse. The same wrap also advances a 7-bit watchdog counter. When the watchdog counter reaches a programmed period, the block pulses either a watchdog interrupt or a CPU reset request. After that match the watchdog counter starts again from zero. Software keeps the watchdog from firing by writing a clear bit at regular intervals. A second self-clearing bit restarts the prescaler and the interval counter.

Software reaches two byte-wide registers through a write-only port. The clock-control register is at address 0xEC and the watchdog register is at 0xED. While `stop_i` is high the system clock is taken to be halted, so the prescaler freezes. If the RC-watchdog enable bit is set, each cycle with `rc_tick_i` high then counts as one interval tick, and the watchdog keeps running during stop mode.

Top module: `wdog_interval_timer`

## Requirements
- R1: After reset the clock-control register selects division by 1024, reset mode and no RC source. The first interval pulse comes 1024·2^ICNT_W cycles after reset is released.
- R2: Clock-control bits [2:0] hold a select code k. Code k makes the prescaler emit one tick every 2^(k+3) cycles, so 000 gives ÷8 and 111 gives ÷1024.
- R3: The ICNT_W-bit interval counter wraps after 2^ICNT_W ticks. Each wrap makes `bit_irq_o` high for exactly one cycle, one cycle after the tick that caused it.
- R4: Each wrap advances the watchdog counter. The match comes on the wrap that brings the counter to the period held in watchdog-register bits [6:0]. The counter then restarts from zero, so matches repeat every `period` wraps.
- R5: Clock-control bit 4 selects the action on a match. With bit 4 = 1, `rst_req_o` pulses for one cycle. With bit 4 = 0, `wdt_irq_o` pulses for one cycle. The pulse comes in the same cycle as the `bit_irq_o` pulse of that wrap, and the other output stays low.
- R6: Writing the watchdog register with bit 7 = 1 zeroes the watchdog counter on the edge after the write. The bit clears itself, and the prescaler and interval counter are not affected.
- R7: Writing the clock-control register with bit 3 = 1 zeroes the prescaler and the interval counter on the edge after the write. The bit clears itself and the watchdog counter keeps its value.
- R8: While `stop_i` is high and clock-control bit 5 (RC enable) is 0, nothing counts and `rc_tick_i` has no effect. Counting resumes where it stopped when `stop_i` falls.
- R9: While `stop_i` is high and clock-control bit 5 is 1, every cycle with `rc_tick_i` high counts as one interval tick, and the prescaler stays frozen.
- R10: While `stop_i` is low, `rc_tick_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write address (0xEC clock control, 0xED watchdog) |
| wr_data_i | input | 8 | Write data |
| stop_i | input | 1 | Stop mode: system clock halted |
| rc_tick_i | input | 1 | Tick from the internal RC oscillator |
| bit_irq_o | output | 1 | Interval-timer interrupt pulse |
| wdt_irq_o | output | 1 | Watchdog interrupt pulse (interrupt mode) |
| rst_req_o | output | 1 | CPU reset request pulse (reset mode) |

## Verification
The bench builds the block with ICNT_W = 4, so the interval counter wraps every 16 ticks instead of 256. One wrap then takes 128 cycles at ÷8 and 16384 cycles at the reset default of ÷1024. This brings several consecutive watchdog matches, a counter clear in mid-period, a prescaler restart and both stop-mode sources within a short run. The reset-default divider and the reset action are still covered.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W        = 8;
  localparam int DIV_SEL_W    = 3;
  localparam int MIN_DIV_LOG2 = 3;
  localparam int N_DIV        = 1 << DIV_SEL_W;
  localparam int PRESC_W      = MIN_DIV_LOG2 + N_DIV - 1;

  // clock-control bit positions
  localparam int CK_RC_BIT   = 5;
  localparam int CK_MODE_BIT = 4;
  localparam int CK_CLR_BIT  = 3;
  // watchdog register clear bit
  localparam int WD_CLR_BIT  = 7;

  typedef struct packed {
    logic                 rc_en;
    logic                 rst_mode;
    logic [DIV_SEL_W-1:0] div_sel;
  } ckctl_t;

  localparam ckctl_t CKCTL_RST = '{rc_en: 1'b0, rst_mode: 1'b1, div_sel: '1};
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int SEL_W    = 3,
  parameter int MIN_LOG2 = 3,
  localparam int NSEL    = 1 << SEL_W,
  localparam int CNT_W   = MIN_LOG2 + NSEL - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [NSEL-1:0]  tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

  // tap k fires when the low (k+MIN_LOG2) bits are all ones
  for (genvar k = 0; k < NSEL; k++) begin : g_tap
    assign tap[k] = &cnt_q[MIN_LOG2+k-1:0];
  end

  assign tick_o = run_i & tap[sel_i];
endmodule

// File: rtl/wdog_interval_cnt.sv
module wdog_interval_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_o = tick_i & (&cnt_q);
  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_match_cnt.sv
module wdog_match_cnt #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         clr_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] nxt;

  assign nxt     = cnt_q + 1'b1;
  assign match_o = adv_i & ~clr_i & (nxt == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (match_o)  cnt_q <= '0;
    else if (adv_i)    cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_interval_timer.sv
module wdog_interval_timer
  import wdog_pkg::*;
#(
  parameter int ICNT_W = 8,
  parameter int WCNT_W = 7,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CKCTL_ADDR = 8'hEC,
  parameter logic [ADDR_W-1:0] WDOG_ADDR  = 8'hED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              stop_i,
  input  logic              rc_tick_i,
  output logic              bit_irq_o,
  output logic              wdt_irq_o,
  output logic              rst_req_o
);
  ckctl_t            ck_q;
  logic [WCNT_W-1:0] period_q;
  logic              btcl_p, wclr_p;
  logic              presc_tick, int_tick, ovf, match;
  logic              rc_en, rst_mode;
  logic [ICNT_W-1:0] icnt;
  logic [WCNT_W-1:0] wcnt;
  logic              bit_irq_q, wdt_irq_q, rst_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q     <= CKCTL_RST;
      period_q <= '1;
      btcl_p   <= 1'b0;
      wclr_p   <= 1'b0;
    end else begin
      btcl_p <= 1'b0;
      wclr_p <= 1'b0;
      if (wr_en_i && wr_addr_i == CKCTL_ADDR) begin
        ck_q.rc_en    <= wr_data_i[CK_RC_BIT];
        ck_q.rst_mode <= wr_data_i[CK_MODE_BIT];
        ck_q.div_sel  <= wr_data_i[DIV_SEL_W-1:0];
        btcl_p        <= wr_data_i[CK_CLR_BIT];
      end
      if (wr_en_i && wr_addr_i == WDOG_ADDR) begin
        period_q <= wr_data_i[WCNT_W-1:0];
        wclr_p   <= wr_data_i[WD_CLR_BIT];
      end
    end
  end

  assign rc_en    = ck_q.rc_en;
  assign rst_mode = ck_q.rst_mode;

  wdog_prescaler #(.SEL_W(DIV_SEL_W), .MIN_LOG2(MIN_DIV_LOG2)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (~stop_i),
    .clr_i  (btcl_p),
    .sel_i  (ck_q.div_sel),
    .tick_o (presc_tick)
  );

  // stop mode: system ticks vanish, RC ticks count only when armed
  assign int_tick = ~btcl_p & (stop_i ? (rc_en & rc_tick_i) : presc_tick);

  wdog_interval_cnt #(.W(ICNT_W)) u_icnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (int_tick),
    .clr_i  (btcl_p),
    .cnt_o  (icnt),
    .ovf_o  (ovf)
  );

  wdog_match_cnt #(.W(WCNT_W)) u_wcnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (ovf),
    .clr_i    (wclr_p),
    .period_i (period_q),
    .cnt_o    (wcnt),
    .match_o  (match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_irq_q <= 1'b0;
      wdt_irq_q <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      bit_irq_q <= ovf;
      wdt_irq_q <= match & ~rst_mode;
      rst_req_q <= match & rst_mode;
    end
  end

  assign bit_irq_o = bit_irq_q;
  assign wdt_irq_o = wdt_irq_q;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int ICNT_W = 8,
  parameter int WCNT_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              rc_en_i,
  input logic              btcl_i,
  input logic              wclr_i,
  input logic              rst_mode_i,
  input logic [ICNT_W-1:0] icnt_i,
  input logic [WCNT_W-1:0] wcnt_i,
  input logic              bit_irq_i,
  input logic              wdt_irq_i,
  input logic              rst_req_i
);
  AST_BIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_irq_i |=> !bit_irq_i); // R3
  AST_ACTION_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdt_irq_i && rst_req_i)); // R5
  AST_MATCH_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_irq_i || rst_req_i) |-> bit_irq_i); // R5
  AST_RST_IN_RST_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> $past(rst_mode_i)); // R5
  AST_IRQ_IN_IRQ_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_irq_i |-> !$past(rst_mode_i)); // R5
  AST_WCLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wclr_i |=> (wcnt_i == '0)); // R6
  AST_BTCL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btcl_i |=> (icnt_i == '0)); // R7
  AST_BTCL_KEEP_WCNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btcl_i && !wclr_i) |=> $stable(wcnt_i)); // R7
  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !rc_en_i && !btcl_i) |=> $stable(icnt_i)); // R8
endmodule

bind wdog_interval_timer wdog_checker #(.ICNT_W(ICNT_W), .WCNT_W(WCNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_i     (stop_i),
  .rc_en_i    (rc_en),
  .btcl_i     (btcl_p),
  .wclr_i     (wclr_p),
  .rst_mode_i (rst_mode),
  .icnt_i     (icnt),
  .wcnt_i     (wcnt),
  .bit_irq_i  (bit_irq_o),
  .wdt_irq_i  (wdt_irq_o),
  .rst_req_i  (rst_req_o)
);

// File: tb/sim_wdog_interval_timer.sv
`timescale 1ns/1ps
module sim_wdog_interval_timer;
  localparam int ICNT_W = 4;
  localparam int NWRAP  = 1 << ICNT_W;
  localparam logic [7:0] A_CK = 8'hEC;
  localparam logic [7:0] A_WD = 8'hED;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       stop = 1'b0;
  logic       rc_tick = 1'b0;
  logic       bit_irq, wdt_irq, rst_req;

  always #2 clk = ~clk;

  wdog_interval_timer #(.ICNT_W(ICNT_W)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .stop_i    (stop),
    .rc_tick_i (rc_tick),
    .bit_irq_o (bit_irq),
    .wdt_irq_o (wdt_irq),
    .rst_req_o (rst_req)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; int kind; string req; } exp_t;
  exp_t q[$];
  int checks = 0;
  int errors = 0;
  string nm [3] = '{"bit_irq_o", "wdt_irq_o", "rst_req_o"};

  task automatic push(input int at, input int kind, input string req);
    exp_t e;
    e.at = at; e.kind = kind; e.req = req;
    q.push_back(e);
  endtask

  // monitor: pop and compare on every observed pulse
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] obs;
      obs = {rst_req, wdt_irq, bit_irq};
      for (int k = 0; k < 3; k++) begin
        if (obs[k]) begin
          checks++;
          if (q.size() == 0) begin
            errors++;
            $display("FAIL unexpected: %s at cycle %0d, expected none", nm[k], cyc);
          end else begin
            exp_t e;
            e = q.pop_front();
            if (e.at != cyc || e.kind != k) begin
              errors++;
              $display("FAIL %s: got %s at cycle %0d, expected %s at cycle %0d",
                       e.req, nm[k], cyc, nm[e.kind], e.at);
            end
          end
        end
      end
    end
  end

  task automatic drain();
    while (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      errors++;
      $display("FAIL %s: got no %s, expected it at cycle %0d", e.req, nm[e.kind], e.at);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr_now(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(output int n);
    @(negedge clk);
    rst_n = 1'b0; stop = 1'b0; rc_tick = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (bit_irq !== 1'b0 || wdt_irq !== 1'b0 || rst_req !== 1'b0) begin
      errors++;
      $display("FAIL R1: outputs in reset %b%b%b, expected 000", bit_irq, wdt_irq, rst_req);
    end
    rst_n = 1'b1;
    n = cyc;
    @(negedge clk);
  endtask

  // reset, write watchdog reg then clock control with its clear bit; returns restart edge
  task automatic start(input logic [7:0] wd, input logic [7:0] ck, output int e0);
    int n;
    do_reset(n);
    wr_now(A_WD, wd);
    wr_now(A_CK, ck);
    e0 = n + 4;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e0, e1, n;

    // T1: reset defaults (div 1024, reset mode), period 2
    do_reset(n);
    wr_now(A_WD, 8'h82);
    push(n + 1024 * NWRAP, 0, "R1");
    push(n + 2 * 1024 * NWRAP, 0, "R1");
    push(n + 2 * 1024 * NWRAP, 2, "R1");
    wait_until(n + 2 * 1024 * NWRAP + 10);
    drain();

    // T2: div 8, interrupt mode, period 3, periodic matches
    start(8'h83, 8'h08, e0);
    for (int k = 1; k <= 7; k++) begin
      push(e0 + 128 * k, 0, "R2");
      if (k % 3 == 0) push(e0 + 128 * k, 1, "R4");
    end
    wait_until(e0 + 128 * 7 + 20);
    drain();

    // T3: div 16, reset mode, period 2, rc_tick high without stop (R10)
    start(8'h82, 8'h19, e0);
    rc_tick = 1'b1;
    push(e0 + 256, 0, "R10");
    push(e0 + 512, 0, "R3");
    push(e0 + 512, 2, "R5");
    push(e0 + 768, 0, "R10");
    wait_until(e0 + 800);
    rc_tick = 1'b0;
    drain();

    // T4: watchdog clear in mid-period delays the match
    start(8'h83, 8'h08, e0);
    for (int k = 1; k <= 5; k++) push(e0 + 128 * k, 0, "R6");
    push(e0 + 640, 1, "R6");
    wait_until(e0 + 300);
    wr_now(A_WD, 8'h83);
    wait_until(e0 + 660);
    drain();

    // T5: interval clear restarts prescaler, keeps watchdog count
    start(8'h85, 8'h08, e0);
    push(e0 + 128, 0, "R7");
    wait_until(e0 + 200);
    wr_now(A_CK, 8'h08);
    e1 = e0 + 202;
    for (int k = 1; k <= 4; k++) push(e1 + 128 * k, 0, "R7");
    push(e1 + 512, 1, "R7");
    wait_until(e1 + 532);
    drain();

    // T6: stop without RC source freezes counting, rc_tick ignored
    start(8'h82, 8'h08, e0);
    push(e0 + 428, 0, "R8");
    push(e0 + 556, 0, "R8");
    push(e0 + 556, 1, "R8");
    wait_until(e0 + 50);
    stop = 1'b1; rc_tick = 1'b1;
    wait_until(e0 + 350);
    stop = 1'b0; rc_tick = 1'b0;
    wait_until(e0 + 600);
    drain();

    // T7: stop with RC source armed, counting on rc_tick
    start(8'h82, 8'h28, e0);
    wait_until(e0 + 1);
    stop = 1'b1;
    for (int j = 1; j <= 32; j++) begin
      if (j % NWRAP == 0) push(e0 + 4 * j + 1, 0, "R9");
      if (j == 2 * NWRAP) push(e0 + 4 * j + 1, 1, "R9");
      wait_until(e0 + 4 * j);
      rc_tick = 1'b1;
      @(negedge clk);
      rc_tick = 1'b0;
    end
    wait_until(e0 + 4 * 32 + 10);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule